// File: doc/BRIEF.md
# Twelve-Bit Reloading PWM Timer

This block is a timer for lamp and motor drive. It is built around an up-counter that starts again from a programmable floor each time it passes its top value. Four output channels each compare the count against a duty threshold. An output is high while the count lies between the floor and its threshold. A polarity bit per channel inverts the output. Duty thresholds are written into holding registers and take effect only at a wrap of the counter, and only when software has armed a transfer.

Around the counter sit four further functions. A compare flag fires when the count steps onto the duty value of channel 0. A capture register takes the count on a rising edge of an external input. A safety input, active low, can latch the outputs to fixed levels. Software works the block through a byte-wide register bank with read-to-clear event flags and per-event interrupt enables. The counter advances on one of several tick sources, picked by a 2-bit select field.

Top module: `pwm_reload_timer`

## Requirements
- R1: Each selected tick raises the count by one. A tick taken while the count is at its maximum (FFFh for 12 bits) instead loads the reload value (address 02h low byte, 03h bits 3:0 high) and sets the overflow flag. The count reads back at 09h (low byte) and 0Ah (high bits).
- R2: Bits 1:0 of the control register (address 00h) pick the tick source: 0 holds the count, 1 uses `tick_ms` pulses, 2 counts every clock, 3 uses `tick_fast` pulses. Ticks from a source that is not selected have no effect.
- R3: The unforced level of a channel is 1 exactly when reload <= count < active duty. A duty at or below the reload value therefore keeps that channel low.
- R4: Duty writes go to 10h+2n (low byte) and 11h+2n (high bits) and do not change any output by themselves. The active duty is loaded from these registers only at a wrap, and only if bit 0 of the transfer register (04h) is 1. That wrap clears the transfer bit.
- R5: Bit n of the polarity register (05h) inverts output n.
- R6: With compare mode on (control bit 2), a tick that moves the count onto the duty register value of channel 0 sets the compare flag.
- R7: A rising edge on `cap_in`, taken through a two-stage synchroniser, copies the count into the capture register (07h low, 08h high) and sets the capture flag. A falling edge does nothing.
- R8: The break register (06h) holds an enable in bit 0 and one forced level per channel in bits 4:1. While the enable is set, a synchronised low on `brk_n` latches a break state (status bit 3), and `pwm_o` then equals the forced levels. The state stays latched after `brk_n` returns high, until the break register is written. With the enable at 0, `brk_n` has no effect.
- R9: The status register (01h) shows overflow (bit 0), capture (bit 1) and compare (bit 2). A read of 01h clears those three flags. Each interrupt output is its flag gated by its enable in the control register: bit 3 for overflow, bit 4 for capture, bit 5 for compare.
- R10: After reset the control, reload, transfer, polarity, break and duty registers are 0, the count is 0, no flag is set and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of status clears its flags |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| tick_ms | input | 1 | Slow timebase tick, one clock wide |
| tick_fast | input | 1 | Fast tick enable |
| cap_in | input | 1 | Capture trigger, asynchronous |
| brk_n | input | 1 | Break request, active low, asynchronous |
| pwm_o | output | 4 | Channel outputs |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cap | output | 1 | Capture interrupt |
| irq_cmp | output | 1 | Compare interrupt |

## Verification
Count, flags, active duties and break state are registers that change at the edge where the strobe or tick is seen. The outputs and `rdata` follow combinationally, so results written by a write or a tick can be read one clock later. Results that come through the synchronisers land on the third edge after the input changes. The bench therefore waits at least four clocks before checking capture or break results. It drives every input just after a falling edge and samples just after the next falling edge. Whenever an exact count is required, it moves the counter with single tick pulses. After any free run it stops the counter and reads back the count, then works out the expected outputs from that value.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned MAXW = 16;

  // unforced channel level: high between floor and threshold
  function automatic logic chan_level(input logic [MAXW-1:0] count,
                                      input logic [MAXW-1:0] floor_v,
                                      input logic [MAXW-1:0] thresh);
    return (count >= floor_v) && (count < thresh);
  endfunction

  // value the counter takes on a tick
  function automatic logic [MAXW-1:0] step_value(input logic [MAXW-1:0] count,
                                                 input logic [MAXW-1:0] top_v,
                                                 input logic [MAXW-1:0] floor_v);
    return (count == top_v) ? floor_v : count + 1'b1;
  endfunction
endpackage

// File: rtl/prt_counter.sv
module prt_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_sel,
  input  logic          tick_ms,
  input  logic          tick_fast,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx,
  output logic          step,
  output logic          wrap
);
  import prt_pkg::*;
  localparam logic [CW-1:0] TOP = '1;

  always_comb begin
    unique case (src_sel)
      2'd0: step = 1'b0;
      2'd1: step = tick_ms;
      2'd2: step = 1'b1;
      default: step = tick_fast;
    endcase
  end

  assign wrap     = step && (count == TOP);
  assign count_nx = CW'(step_value(MAXW'(count), MAXW'(TOP), MAXW'(reload)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count_nx;
  end

  p_wrap_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == $past(reload));
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 2'd0 |=> $stable(count));
endmodule

// File: rtl/prt_channel.sv
module prt_channel #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_wr,
  input  logic          load,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] reload,
  input  logic          invert,
  input  logic          forced,
  input  logic          forced_lvl,
  output logic          pwm
);
  import prt_pkg::*;
  logic [CW-1:0] duty_act;
  logic          level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_act <= '0;
    else if (load) duty_act <= duty_wr;
  end

  assign level = chan_level(MAXW'(count), MAXW'(reload), MAXW'(duty_act));
  assign pwm   = forced ? forced_lvl : (level ^ invert);

  p_low_at_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && duty_act <= reload) |-> pwm == invert);
  p_duty_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_act));
endmodule

// File: rtl/prt_capture.sv
module prt_capture #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_in,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap_val,
  output logic          cap_evt
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cap_in};
  end

  assign cap_evt = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= count;
  end

  p_cap_takes_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_val == $past(count));
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int unsigned CW  = 12,
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic           tick_ms,
  input  logic           tick_fast,
  input  logic           cap_in,
  input  logic           brk_n,
  output logic [NCH-1:0] pwm_o,
  output logic           irq_ovf,
  output logic           irq_cap,
  output logic           irq_cmp
);
  localparam logic [AW-1:0] A_CTRL = AW'(0),  A_STAT = AW'(1),  A_RLDL = AW'(2);
  localparam logic [AW-1:0] A_RLDH = AW'(3),  A_XFER = AW'(4),  A_POL  = AW'(5);
  localparam logic [AW-1:0] A_BRK  = AW'(6),  A_CAPL = AW'(7),  A_CAPH = AW'(8);
  localparam logic [AW-1:0] A_CNTL = AW'(9),  A_CNTH = AW'(10);
  localparam int unsigned   DUTY_BASE = 16;
  localparam int unsigned   HB = CW - 8;

  logic [5:0]     ctrl;
  logic [CW-1:0]  reload, count, count_nx, cap_val;
  logic           xfer, step, wrap, cap_evt, cmp_evt;
  logic [NCH-1:0] pol, brk_lvl;
  logic           brk_en, brk_act;
  logic [1:0]     brk_sync;
  logic           ovf_f, cap_f, cmp_f, stat_rd;
  logic [CW-1:0]  duty_wr [NCH];

  assign stat_rd = rd_en && (addr == A_STAT);
  assign cmp_evt = ctrl[2] && step && (count_nx == duty_wr[0]);

  prt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .src_sel(ctrl[1:0]), .tick_ms(tick_ms),
    .tick_fast(tick_fast), .reload(reload), .count(count),
    .count_nx(count_nx), .step(step), .wrap(wrap));

  prt_capture #(.CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .count(count),
    .cap_val(cap_val), .cap_evt(cap_evt));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    prt_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr[i]), .load(wrap && xfer),
      .count(count), .reload(reload), .invert(pol[i]), .forced(brk_act),
      .forced_lvl(brk_lvl[i]), .pwm(pwm_o[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; reload <= '0; xfer <= 1'b0; pol <= '0;
      brk_en <= 1'b0; brk_lvl <= '0;
      for (int i = 0; i < NCH; i++) duty_wr[i] <= '0;
    end else begin
      if (wr_en) begin
        if (addr == A_CTRL) ctrl <= wdata[5:0];
        if (addr == A_RLDL) reload[7:0] <= wdata;
        if (addr == A_RLDH) reload[CW-1:8] <= wdata[HB-1:0];
        if (addr == A_POL)  pol <= wdata[NCH-1:0];
        if (addr == A_BRK) begin
          brk_en  <= wdata[0];
          brk_lvl <= wdata[NCH:1];
        end
        for (int i = 0; i < NCH; i++) begin
          if (addr == AW'(DUTY_BASE + 2*i))     duty_wr[i][7:0]    <= wdata;
          if (addr == AW'(DUTY_BASE + 2*i + 1)) duty_wr[i][CW-1:8] <= wdata[HB-1:0];
        end
      end
      if (wr_en && addr == A_XFER) xfer <= wdata[0];
      else if (wrap)               xfer <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_sync <= 2'b11; brk_act <= 1'b0;
      ovf_f <= 1'b0; cap_f <= 1'b0; cmp_f <= 1'b0;
    end else begin
      brk_sync <= {brk_sync[0], brk_n};
      if (brk_en && !brk_sync[1])       brk_act <= 1'b1;
      else if (wr_en && addr == A_BRK)  brk_act <= 1'b0;
      ovf_f <= wrap    || (ovf_f && !stat_rd);
      cap_f <= cap_evt || (cap_f && !stat_rd);
      cmp_f <= cmp_evt || (cmp_f && !stat_rd);
    end
  end

  assign irq_ovf = ovf_f && ctrl[3];
  assign irq_cap = cap_f && ctrl[4];
  assign irq_cmp = cmp_f && ctrl[5];

  always_comb begin
    rdata = 8'h00;
    unique case (addr)
      A_CTRL: rdata = {2'b00, ctrl};
      A_STAT: rdata = {4'h0, brk_act, cmp_f, cap_f, ovf_f};
      A_RLDL: rdata = reload[7:0];
      A_RLDH: rdata = 8'(reload >> 8);
      A_XFER: rdata = {7'h00, xfer};
      A_POL:  rdata = 8'(pol);
      A_BRK:  rdata = 8'({brk_lvl, brk_en});
      A_CAPL: rdata = cap_val[7:0];
      A_CAPH: rdata = 8'(cap_val >> 8);
      A_CNTL: rdata = count[7:0];
      A_CNTH: rdata = 8'(count >> 8);
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addr == AW'(DUTY_BASE + 2*i))     rdata = duty_wr[i][7:0];
          if (addr == AW'(DUTY_BASE + 2*i + 1)) rdata = 8'(duty_wr[i] >> 8);
        end
      end
    endcase
  end

  p_xfer_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && xfer && !(wr_en && addr == A_XFER)) |=> !xfer);
  p_break_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_act |-> pwm_o == brk_lvl);
  p_cmp_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_f);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wrap && !cap_evt && !cmp_evt) |=> !(ovf_f || cap_f || cmp_f));
  p_cap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_f);
endmodule

// File: tb/test_pwm_reload_timer.sv
module test_pwm_reload_timer;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic tick_ms = 1'b0, tick_fast = 1'b0, cap_in = 1'b0, brk_n = 1'b1;
  logic [3:0] pwm_o;
  logic irq_ovf, irq_cap, irq_cmp;

  int total = 0, bad = 0;
  int rl = 0;
  int act [4] = '{0, 0, 0, 0};
  int pol = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_reload_timer i_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_ms(tick_ms), .tick_fast(tick_fast),
    .cap_in(cap_in), .brk_n(brk_n), .pwm_o(pwm_o), .irq_ovf(irq_ovf),
    .irq_cap(irq_cap), .irq_cmp(irq_cmp));

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = 5'(a); #1 d = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic get_count(output int c);
    int lo, hi;
    rd(9, lo); rd(10, hi); c = hi * 256 + lo;
  endtask

  task automatic pulse_ms(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0;
    end
  endtask

  task automatic pulse_fast(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_fast = 1'b1; @(negedge clk); tick_fast = 1'b0;
    end
  endtask

  function automatic int exp_pwm(input int c);
    int v = 0;
    for (int i = 0; i < 4; i++)
      if (((c >= rl && c < act[i]) ? 1 : 0) != ((pol >> i) & 1)) v |= (1 << i);
    return v;
  endfunction

  task automatic t_reset;
    int d, c;
    @(negedge clk);
    chk("R10 pwm_o", int'(pwm_o), 0);
    chk("R10 irqs", int'({irq_ovf, irq_cap, irq_cmp}), 0);
    rd(1, d); chk("R10 status", d, 0);
    rd(0, d); chk("R10 ctrl", d, 0);
    rd(4, d); chk("R10 xfer", d, 0);
    get_count(c); chk("R10 count", c, 0);
  endtask

  task automatic t_clock_sel;
    int c;
    wr(0, 8'h01);
    pulse_fast(2); get_count(c); chk("R2 fast ignored in ms mode", c, 0);
    pulse_ms(3);   get_count(c); chk("R1 ms ticks", c, 3);
    wr(0, 8'h03);
    pulse_ms(2);   get_count(c); chk("R2 ms ignored in fast mode", c, 3);
    pulse_fast(2); get_count(c); chk("R2 fast ticks", c, 5);
    wr(0, 8'h00);
    pulse_ms(2); pulse_fast(2); repeat (5) @(negedge clk);
    get_count(c); chk("R2 stopped", c, 5);
  endtask

  task automatic t_compare;
    int d;
    wr(16, 8); wr(17, 0);
    wr(0, 8'h25);
    pulse_ms(2);
    chk("R6 no compare before match", int'(irq_cmp), 0);
    rd(1, d); chk("R6 status before match", d & 4, 0);
    pulse_ms(1);
    chk("R9 compare irq", int'(irq_cmp), 1);
    rd(1, d); chk("R6 compare flag", d & 4, 4);
    rd(1, d); chk("R9 read clears", d & 7, 0);
    chk("R9 irq after clear", int'(irq_cmp), 0);
  endtask

  task automatic t_capture;
    int d, h;
    wr(0, 8'h11);
    @(negedge clk); cap_in = 1'b1; repeat (6) @(negedge clk);
    chk("R9 capture irq", int'(irq_cap), 1);
    rd(7, d); rd(8, h); chk("R7 captured count", h * 256 + d, 8);
    rd(1, d); chk("R7 capture flag", d & 2, 2);
    pulse_ms(2);
    @(negedge clk); cap_in = 1'b0; repeat (6) @(negedge clk);
    rd(1, d); chk("R7 falling edge ignored", d & 2, 0);
    rd(7, d); chk("R7 value kept", d, 8);
    @(negedge clk); cap_in = 1'b1; repeat (6) @(negedge clk);
    rd(7, d); chk("R7 second capture", d, 10);
  endtask

  task automatic t_pwm;
    int c, d;
    int dv [4] = '{'hF80, 'hE00, 'hF00, 'hFFF};
    wr(0, 8'h00);
    wr(2, 8'h00); wr(3, 8'h0F); rl = 'hF00;
    for (int i = 0; i < 4; i++) begin
      wr(16 + 2*i, dv[i] & 255); wr(17 + 2*i, dv[i] >> 8);
    end
    wr(4, 1);
    rd(4, d); chk("R4 transfer armed", d, 1);
    chk("R4 no effect before wrap", int'(pwm_o), 0);
    wr(0, 8'h0A);
    repeat (4200) @(negedge clk);
    wr(0, 8'h08);
    for (int i = 0; i < 4; i++) act[i] = dv[i];
    get_count(c);
    chk("R1 reloaded range", (c >= 'hF00 && c < 'hF80) ? 1 : 0, 1);
    chk("R9 overflow irq", int'(irq_ovf), 1);
    rd(1, d); chk("R1 overflow flag", d & 1, 1);
    rd(1, d); chk("R9 overflow cleared", d & 1, 0);
    rd(4, d); chk("R4 transfer cleared", d, 0);
    @(negedge clk); chk("R3 mid period", int'(pwm_o), exp_pwm(c));
    chk("R3 pattern 1001", int'(pwm_o), 4'b1001);
    wr(0, 8'h09);
    pulse_ms('hF7F - c);
    get_count(c); chk("R3 count at F7F", c, 'hF7F);
    chk("R3 before threshold", int'(pwm_o), exp_pwm(c));
    pulse_ms(1);
    get_count(c);
    chk("R3 at threshold", int'(pwm_o), exp_pwm(c));
    chk("R3 ch0 low at duty", int'(pwm_o[0]), 0);
    wr(18, 8'hF0); wr(19, 8'h0F);
    @(negedge clk); chk("R4 duty write ignored", int'(pwm_o), exp_pwm(c));
    wr(5, 8'h05); pol = 5;
    @(negedge clk); chk("R5 polarity", int'(pwm_o), exp_pwm(c));
    chk("R5 pattern 1101", int'(pwm_o), 4'b1101);
  endtask

  task automatic t_break;
    int c, d;
    get_count(c);
    wr(6, 8'h05);
    @(negedge clk); brk_n = 1'b0; repeat (4) @(negedge clk);
    chk("R8 forced levels", int'(pwm_o), 4'b0010);
    rd(1, d); chk("R8 break status", d & 8, 8);
    @(negedge clk); brk_n = 1'b1; repeat (4) @(negedge clk);
    chk("R8 stays latched", int'(pwm_o), 4'b0010);
    wr(6, 8'h05);
    @(negedge clk); chk("R8 released", int'(pwm_o), exp_pwm(c));
    wr(6, 8'h04);
    @(negedge clk); brk_n = 1'b0; repeat (4) @(negedge clk);
    chk("R8 disabled", int'(pwm_o), exp_pwm(c));
    rd(1, d); chk("R8 no status when disabled", d & 8, 0);
    @(negedge clk); brk_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_clock_sel;
    t_compare;
    t_capture;
    t_pwm;
    t_break;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule